// File: doc/BRIEF.md
# Fractional-Divider Serial Transceiver

This block is a full-duplex asynchronous serial port. It drives one transmit line and samples one receive line. Every frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. A small register port lets software set the enables, set the bit rate, poll the flags and move bytes in and out.

The bit rate comes from a sample tick. The tick period is a 12.4 fixed-point number of clock cycles, so the integer part counts whole cycles and the low four bits count sixteenths of a cycle. A phase accumulator advances by one sixteenth-scaled step per clock, which keeps the average tick period equal to the programmed value with no long-term drift. Each bit lasts either 16 or 8 ticks, as the oversampling select bit chooses. To get a divider for a given rate, divide the clock frequency by the rate times the ticks per bit. For example, a divider of 25.125 is written as integer 25 and fraction 2.

The transmitter has a one-byte holding register in front of its shift register. The port therefore reports two separate things: that the holding register is free, and that the line has gone idle. The receiver confirms a start bit at its middle and takes each bit by majority vote of three samples around the bit centre. It reports framing errors and overruns.

Top module: `fbu_uart`

## Requirements
- R1: The divider register at address 1 holds an integer part in bits 15:4 and a fraction in sixteenths in bits 3:0, and it resets to 0x0010. The tick period averages divider/16 clocks, and any run of N whole ticks spans N*divider/16 clocks within one clock. Values below 0x0010 act as 0x0010.
- R2: Control bit 3 (address 0) selects 8 ticks per bit when it is 1 and 16 ticks per bit when it is 0.
- R3: Control bit 0 is the global enable, bit 1 enables transmit and bit 2 enables receive. A direction shifts only when bit 0 and its own bit are both 1. While transmit is gated off, the line stays high and a pending byte stays pending.
- R4: A transmitted frame is a low start bit, then data bits LSB first, then a high stop bit. The line idles high.
- R5: Status bit 1 (address 2) is the transmit-buffer-empty flag. It is 1 after reset, goes to 0 on a write to the data register (address 3), and goes back to 1 when the byte moves into the shift register.
- R6: Status bit 2 is transmission-complete. It is 1 after reset and is cleared by a data-register write. It is set only when a stop bit ends and no byte is pending.
- R7: Status bit 0 is the receive-ready flag. It is set when a byte arrives. Reading the data register returns that byte and clears the flag.
- R8: Each received bit is the majority of three samples at the bit centre, so a one-clock glitch at the centre of a bit does not change the byte.
- R9: Status bit 3 is 1 when the stop bit of the last accepted byte was sampled low. It is updated with every accepted byte.
- R10: A byte that completes while receive-ready is still 1 is discarded and sets status bit 4 (overrun). A data-register read clears overrun.
- R11: When a data-register read and a byte completion fall in the same cycle, the read returns the old byte. The new byte is then kept, receive-ready stays 1 and overrun stays 0.
- R12: A low pulse on the receive line that is shorter than half a bit is rejected as a false start and produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select: 0 control, 1 divider, 2 status, 3 data |
| regWr | input | 1 | Write strobe for the selected register |
| regRd | input | 1 | Read strobe; on the data register it consumes the byte |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the selected register (combinational) |
| rxLine | input | 1 | Serial receive line |
| txLine | output | 1 | Serial transmit line |

## Verification
The data-register read and the completion of an incoming byte can land on the same clock edge. That edge decides whether the new byte is kept or counted as an overrun. The bench provokes this case in two steps. It first sends a calibration frame at a divider of one clock per tick and finds the exact edge where receive-ready rises. It then leaves one byte waiting, replays the same frame timing for a second byte, and asserts the read on that exact edge. The result is judged from three things: the value the read returns (the old byte), the flags afterwards (ready set, overrun clear), and the next read (the new byte).

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int MANT_W = 12;
  localparam int FRAC_W = 4;
  localparam int DIV_W  = MANT_W + FRAC_W;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam int REG_W  = 16;
  localparam int CNT_W  = 4;
  localparam int BIT_W  = $clog2(BYTE_W);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_BAUD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd3;

  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(1 << FRAC_W);

  typedef enum logic [1:0] {LN_IDLE, LN_START, LN_DATA, LN_STOP} lineState_t;

  typedef struct packed {
    logic              txGate;
    logic              rxGate;
    logic              over8;
    logic              txLoad;
    logic [BYTE_W-1:0] txByte;
    logic [DIV_W-1:0]  divisor;
  } dpCmd_t;

  typedef struct packed {
    logic              txIdle;
    logic              txFinish;
    logic              rxValid;
    logic              rxFerr;
    logic [BYTE_W-1:0] rxByte;
  } dpEvt_t;

  typedef struct packed {
    logic overrun;
    logic frameErr;
    logic txDone;
    logic txEmpty;
    logic rxReady;
  } statFlags_t;
endpackage

// File: rtl/fbu_datapath.sv
module fbu_datapath
  import fbu_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  input  logic   rxLine,
  output logic   txLine,
  output dpEvt_t evt
);
  localparam int PH_W = DIV_W + 1;

  // fractional tick generator
  logic             anyGate, tick;
  logic [DIV_W-1:0] divEff;
  logic [PH_W-1:0]  phase, phaseStep;

  assign anyGate   = cmd.txGate | cmd.rxGate;
  assign divEff    = (cmd.divisor < DIV_MIN) ? DIV_MIN : cmd.divisor;
  assign phaseStep = phase + PH_W'(DIV_MIN);
  assign tick      = anyGate && (phaseStep >= PH_W'(divEff));

  always_ff @(posedge clk) begin
    if (!rstN || !anyGate) phase <= '0;
    else if (tick)         phase <= phaseStep - PH_W'(divEff);
    else                   phase <= phaseStep;
  end

  logic [CNT_W-1:0] osMax, voteLo, voteHi;
  assign osMax  = cmd.over8 ? 4'd7 : 4'd15;
  assign voteLo = cmd.over8 ? 4'd3 : 4'd7;
  assign voteHi = voteLo + 4'd2;

  // transmitter
  lineState_t        txState;
  logic [CNT_W-1:0]  txCnt;
  logic [BIT_W-1:0]  txBit;
  logic [BYTE_W-1:0] txShift;

  always_ff @(posedge clk) begin
    if (!rstN || !cmd.txGate) begin
      txState <= LN_IDLE;
      txLine  <= 1'b1;
      txCnt   <= '0;
      txBit   <= '0;
      txShift <= '0;
    end else if (cmd.txLoad) begin
      txState <= LN_START;
      txLine  <= 1'b0;
      txCnt   <= '0;
      txBit   <= '0;
      txShift <= cmd.txByte;
    end else if (tick && txState != LN_IDLE) begin
      if (txCnt == osMax) begin
        txCnt <= '0;
        case (txState)
          LN_START: begin
            txState <= LN_DATA;
            txLine  <= txShift[0];
          end
          LN_DATA: begin
            if (txBit == BIT_W'(BYTE_W - 1)) begin
              txState <= LN_STOP;
              txLine  <= 1'b1;
            end else begin
              txBit   <= txBit + 1'b1;
              txShift <= txShift >> 1;
              txLine  <= txShift[1];
            end
          end
          default: txState <= LN_IDLE;
        endcase
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // receiver
  logic              rxMeta, rxS, maj;
  logic [1:0]        vote;
  lineState_t        rxState;
  logic [CNT_W-1:0]  rxCnt;
  logic [BIT_W-1:0]  rxBit;
  logic [BYTE_W-1:0] rxShift;

  assign maj = (vote[1] & vote[0]) | (vote[1] & rxS) | (vote[0] & rxS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxS    <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !cmd.rxGate) begin
      rxState <= LN_IDLE;
      rxCnt   <= '0;
      rxBit   <= '0;
      vote    <= 2'b11;
      if (!rstN) rxShift <= '0;
    end else if (tick) begin
      if (rxState == LN_IDLE) begin
        if (!rxS) begin
          rxState <= LN_START;
          rxCnt   <= '0;
          rxBit   <= '0;
        end
      end else begin
        if (rxCnt == voteLo || rxCnt == voteLo + 4'd1) vote <= {vote[0], rxS};
        if (rxCnt == voteHi) begin
          if (rxState == LN_START && maj) rxState <= LN_IDLE;
          if (rxState == LN_DATA) rxShift <= {maj, rxShift[BYTE_W-1:1]};
          if (rxState == LN_STOP) rxState <= LN_IDLE;
        end
        if (rxCnt == osMax) begin
          rxCnt <= '0;
          if (rxState == LN_START) rxState <= LN_DATA;
          if (rxState == LN_DATA) begin
            if (rxBit == BIT_W'(BYTE_W - 1)) rxState <= LN_STOP;
            else                             rxBit   <= rxBit + 1'b1;
          end
        end else begin
          rxCnt <= rxCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    evt.txIdle   = (txState == LN_IDLE);
    evt.txFinish = cmd.txGate && tick && txState == LN_STOP && txCnt == osMax;
    evt.rxValid  = cmd.rxGate && tick && rxState == LN_STOP && rxCnt == voteHi;
    evt.rxFerr   = !maj;
    evt.rxByte   = rxShift;
  end
endmodule

// File: rtl/fbu_ctrl.sv
module fbu_ctrl
  import fbu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  ctrlRdata,
  input  dpEvt_t            evt,
  output dpCmd_t            cmd,
  output statFlags_t        flags
);
  logic              ue, te, re, os8;
  logic [DIV_W-1:0]  baudReg;
  logic [BYTE_W-1:0] txBuf, rxBuf;
  logic              txFull, txDone, rxReady, frameErr, overrun;
  logic              wrCtrl, wrBaud, wrData, rdData;

  assign wrCtrl = regWr && regSel == ADDR_CTRL;
  assign wrBaud = regWr && regSel == ADDR_BAUD;
  assign wrData = regWr && regSel == ADDR_DATA;
  assign rdData = regRd && regSel == ADDR_DATA;

  always_comb begin
    cmd.txGate  = ue & te;
    cmd.rxGate  = ue & re;
    cmd.over8   = os8;
    cmd.txLoad  = txFull & evt.txIdle & ue & te;
    cmd.txByte  = txBuf;
    cmd.divisor = baudReg;
    flags.overrun  = overrun;
    flags.frameErr = frameErr;
    flags.txDone   = txDone;
    flags.txEmpty  = !txFull;
    flags.rxReady  = rxReady;
  end

  always_comb begin
    case (regSel)
      ADDR_CTRL: ctrlRdata = {{(REG_W-4){1'b0}}, os8, re, te, ue};
      ADDR_BAUD: ctrlRdata = REG_W'(baudReg);
      default:   ctrlRdata = {{(REG_W-BYTE_W){1'b0}}, rxBuf};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {os8, re, te, ue} <= '0;
      baudReg  <= DIV_MIN;
      txBuf    <= '0;
      txFull   <= 1'b0;
      txDone   <= 1'b1;
      rxBuf    <= '0;
      rxReady  <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (wrCtrl) {os8, re, te, ue} <= regWdata[3:0];
      if (wrBaud) baudReg <= regWdata[DIV_W-1:0];
      if (cmd.txLoad) txFull <= 1'b0;
      if (evt.txFinish && !txFull) txDone <= 1'b1;
      if (wrData) begin
        txBuf  <= regWdata[BYTE_W-1:0];
        txFull <= 1'b1;
        txDone <= 1'b0;
      end
      if (rdData) begin
        rxReady <= 1'b0;
        overrun <= 1'b0;
      end
      if (evt.rxValid) begin
        if (rxReady && !rdData) begin
          overrun <= 1'b1;
        end else begin
          rxBuf    <= evt.rxByte;
          rxReady  <= 1'b1;
          frameErr <= evt.rxFerr;
        end
      end
    end
  end
endmodule

// File: rtl/fbu_uart.sv
module fbu_uart
  import fbu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              rxLine,
  output logic              txLine
);
  dpCmd_t           cmd;
  dpEvt_t           evt;
  statFlags_t       flags;
  logic [REG_W-1:0] ctrlRdata;

  fbu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .ctrlRdata(ctrlRdata), .evt(evt), .cmd(cmd), .flags(flags)
  );

  fbu_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxLine(rxLine), .txLine(txLine), .evt(evt)
  );

  assign regRdata = (regSel == ADDR_STAT) ? {{(REG_W-5){1'b0}}, flags} : ctrlRdata;
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker
  import fbu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regSel,
  input logic              regWr,
  input logic              regRd,
  input logic              txLine,
  input dpCmd_t            cmd,
  input dpEvt_t            evt,
  input statFlags_t        flags
);
  logic dataRd;
  assign dataRd = regRd && regSel == ADDR_DATA;

  assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == ADDR_DATA) |=> !flags.txEmpty);

  assert_done_implies_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    flags.txDone |-> flags.txEmpty);

  assert_gated_line_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.txGate |=> txLine);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !evt.rxValid) |=> !flags.rxReady);

  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rxValid && flags.rxReady && !dataRd) |=> flags.overrun);

  assert_coincide_keeps_R11: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rxValid && dataRd) |=> (flags.rxReady && !flags.overrun));
endmodule

bind fbu_uart fbu_checker u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
  .txLine(txLine), .cmd(cmd), .evt(evt), .flags(flags)
);

// File: tb/sim_fbu_uart.sv
module sim_fbu_uart;
  import fbu_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [ADDR_W-1:0] regSel = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [REG_W-1:0] regWdata = '0;
  logic [REG_W-1:0] regRdata;
  logic txLine, rxLine;
  logic rxDrive = 1'b1, loopOn = 1'b0;
  assign rxLine = loopOn ? txLine : rxDrive;

  fbu_uart u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .rxLine(rxLine), .txLine(txLine)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nBad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] sel, input logic [REG_W-1:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] sel, output logic [REG_W-1:0] d);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic cfg(input int div, input bit over8);
    wr(ADDR_CTRL, 16'h0);
    wr(ADDR_BAUD, REG_W'(div));
    wr(ADDR_CTRL, over8 ? 16'h000F : 16'h0007);
  endtask

  task automatic waitLine(input logic v, output int t);
    @(negedge clk);
    while (txLine !== v) @(negedge clk);
    t = cyc;
  endtask

  task automatic waitDone();
    logic [REG_W-1:0] s;
    s = '0;
    while (!s[2]) rd(ADDR_STAT, s);
  endtask

  task automatic waitReady(output logic [REG_W-1:0] s);
    s = '0;
    for (int n = 0; n < 2000 && !s[0]; n++) rd(ADDR_STAT, s);
  endtask

  // R4/R5/R6: frame shape and flag timing
  task automatic txFrame(input logic [7:0] b, input int div, input bit over8);
    int os, t0, td, target, bitNow, expLen;
    logic [REG_W-1:0] s;
    os = over8 ? 8 : 16;
    cfg(div, over8);
    wr(ADDR_DATA, {8'h00, b});
    waitLine(1'b0, t0);
    for (int i = 0; i < 10; i++) begin
      target = t0 + ((2 * i + 1) * os * div) / 32;
      while (cyc < target) @(negedge clk);
      bitNow = (i == 0) ? 0 : (i == 9) ? 1 : int'(b[i-1]);
      chk(txLine === bitNow[0], "R4 frame bit", int'(txLine), bitNow);
      if (i == 4) begin
        rd(ADDR_STAT, s);
        chk(s[1] == 1'b1, "R5 empty after load", int'(s[1]), 1);
        chk(s[2] == 1'b0, "R6 not done mid-frame", int'(s[2]), 0);
      end
    end
    s = '0;
    while (!s[2]) rd(ADDR_STAT, s);
    td = cyc;
    expLen = (10 * os * div) / 16;
    chk((td - t0 - expLen) <= div / 16 + 3 && (t0 + expLen - td) <= div / 16 + 3,
        "R1 frame length", td - t0, expLen);
  endtask

  // R1/R2: tick-aligned spans measured on the line
  task automatic spanCheck(input int div, input bit over8);
    int os, t0, t1, t2, t3, bt, d1, d7;
    os = over8 ? 8 : 16;
    bt = os * div;
    cfg(div, over8);
    wr(ADDR_DATA, 16'h0001);
    waitLine(1'b0, t0);
    waitLine(1'b1, t1);
    waitLine(1'b0, t2);
    waitLine(1'b1, t3);
    d1 = (t2 - t1) * 16 - bt;
    d7 = (t3 - t2) * 16 - 7 * bt;
    chk(d1 <= 16 && d1 >= -16, "R2 one bit span", t2 - t1, bt / 16);
    chk(d7 <= 16 && d7 >= -16, "R1 seven bit span", t3 - t2, (7 * bt) / 16);
    waitDone();
  endtask

  task automatic sendRx(input logic [7:0] b, input logic stopBit, input int bitClks, input bit glitch);
    logic [9:0] fr;
    fr = {stopBit, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < bitClks; j++) begin
        rxDrive = fr[i] ^ (glitch && i >= 1 && i <= 8 && j == bitClks / 2 + 1);
        @(negedge clk);
      end
    end
    rxDrive = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [REG_W-1:0] s, d, got;
    int t0, c0, c1, k;
    bit stayHigh;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rd(ADDR_STAT, s);
    chk(s[1] == 1'b1, "R5 reset empty", int'(s), 16'h6);
    chk(s[2] == 1'b1 && s[0] == 1'b0, "R6 reset done", int'(s), 16'h6);
    chk(txLine === 1'b1, "R4 idle high", int'(txLine), 1);
    rd(ADDR_BAUD, d);
    chk(d == 16'h0010, "R1 divider reset", int'(d), 16'h10);

    // R3: transmit enable without global enable
    wr(ADDR_CTRL, 16'h0002);
    wr(ADDR_DATA, 16'h0055);
    stayHigh = 1'b1;
    repeat (100) begin @(negedge clk); if (txLine !== 1'b1) stayHigh = 1'b0; end
    chk(stayHigh, "R3 gated tx line high", int'(stayHigh), 1);
    rd(ADDR_STAT, s);
    chk(s[1] == 1'b0, "R3 pending byte kept", int'(s[1]), 0);
    // R3: receive without global enable
    wr(ADDR_CTRL, 16'h0004);
    sendRx(8'h5A, 1'b1, 16, 1'b0);
    repeat (20) @(negedge clk);
    rd(ADDR_STAT, s);
    chk(s[0] == 1'b0, "R3 gated rx no byte", int'(s[0]), 0);
    wr(ADDR_CTRL, 16'h0003);
    waitLine(1'b0, t0);
    chk(1'b1, "R3 enabled tx starts", 0, 0);
    waitDone();

    // R4: frames across configurations
    txFrame(8'hA5, 16, 1'b0);
    txFrame(8'h3C, 57, 1'b1);
    txFrame(8'hC3, 402, 1'b0);
    txFrame(8'h81, 16, 1'b1);

    // R1/R2: fractional spans
    spanCheck(402, 1'b0);
    spanCheck(402, 1'b1);
    spanCheck(57, 1'b1);
    spanCheck(40, 1'b0);

    // R7/R4: exhaustive loopback
    loopOn = 1'b1;
    cfg(16, 1'b1);
    rd(ADDR_DATA, d);
    for (int b = 0; b < 256; b++) begin
      wr(ADDR_DATA, REG_W'(b));
      waitReady(s);
      chk(s[0] == 1'b1, "R7 byte arrives", int'(s), 1);
      chk(s[3] == 1'b0, "R9 clean stop", int'(s[3]), 0);
      rd(ADDR_DATA, d);
      chk(d[7:0] == b[7:0], "R7 loopback data", int'(d[7:0]), b);
      rd(ADDR_STAT, s);
      chk(s[0] == 1'b0, "R7 read clears ready", int'(s[0]), 0);
    end
    waitDone();
    loopOn = 1'b0;

    // R8: centre glitches
    cfg(16, 1'b0);
    rd(ADDR_DATA, d);
    @(negedge clk);
    sendRx(8'h96, 1'b1, 16, 1'b1);
    waitReady(s);
    rd(ADDR_DATA, d);
    chk(d[7:0] == 8'h96, "R8 glitch voted out", int'(d[7:0]), 8'h96);

    // R9: low stop bit, then a good byte
    @(negedge clk);
    sendRx(8'h3A, 1'b0, 16, 1'b0);
    repeat (40) @(negedge clk);
    rd(ADDR_STAT, s);
    chk(s[3] == 1'b1 && s[0] == 1'b1, "R9 framing error", int'(s), 16'h9);
    rd(ADDR_DATA, d);
    chk(d[7:0] == 8'h3A, "R9 data kept", int'(d[7:0]), 8'h3A);
    rd(ADDR_STAT, s);
    chk(s[0] == 1'b0, "R12 no spurious byte after bad stop", int'(s[0]), 0);
    @(negedge clk);
    sendRx(8'h5C, 1'b1, 16, 1'b0);
    waitReady(s);
    chk(s[3] == 1'b0, "R9 flag updated", int'(s[3]), 0);
    rd(ADDR_DATA, d);

    // R10: overrun
    @(negedge clk);
    sendRx(8'h11, 1'b1, 16, 1'b0);
    repeat (20) @(negedge clk);
    sendRx(8'h22, 1'b1, 16, 1'b0);
    repeat (20) @(negedge clk);
    rd(ADDR_STAT, s);
    chk(s[4] == 1'b1 && s[0] == 1'b1, "R10 overrun set", int'(s), 16'h11);
    rd(ADDR_DATA, d);
    chk(d[7:0] == 8'h11, "R10 first byte kept", int'(d[7:0]), 8'h11);
    rd(ADDR_STAT, s);
    chk(s[4] == 1'b0, "R10 overrun cleared", int'(s[4]), 0);

    // R12: short low pulse
    @(negedge clk);
    rxDrive = 1'b0;
    repeat (3) @(negedge clk);
    rxDrive = 1'b1;
    repeat (200) @(negedge clk);
    rd(ADDR_STAT, s);
    chk(s[0] == 1'b0, "R12 false start rejected", int'(s[0]), 0);
    @(negedge clk);
    sendRx(8'h77, 1'b1, 16, 1'b0);
    waitReady(s);
    rd(ADDR_DATA, d);
    chk(d[7:0] == 8'h77, "R12 recovers", int'(d[7:0]), 8'h77);

    // R11: calibrate completion edge, then collide a read with it
    @(negedge clk);
    regSel = ADDR_STAT;
    c1 = 0;
    c0 = cyc;
    fork
      sendRx(8'h41, 1'b1, 16, 1'b0);
      begin
        for (int n = 0; n < 400 && c1 == 0; n++) begin
          #1 if (regRdata[0]) c1 = cyc;
          @(negedge clk);
        end
      end
    join
    k = c1 - c0;
    chk(c1 != 0, "R11 calibration", k, 1);
    rd(ADDR_DATA, d);
    @(negedge clk);
    sendRx(8'h42, 1'b1, 16, 1'b0);
    repeat (20) @(negedge clk);
    got = '0;
    c0 = cyc;
    fork
      sendRx(8'h43, 1'b1, 16, 1'b0);
      begin
        while (cyc < c0 + k - 1) @(negedge clk);
        regSel = ADDR_DATA; regRd = 1'b1;
        #1 got = regRdata;
        @(negedge clk);
        regRd = 1'b0;
      end
    join
    chk(got[7:0] == 8'h42, "R11 read returns old byte", int'(got[7:0]), 8'h42);
    rd(ADDR_STAT, s);
    chk(s[0] == 1'b1 && s[4] == 1'b0, "R11 new byte kept no overrun", int'(s), 16'h1);
    rd(ADDR_DATA, d);
    chk(d[7:0] == 8'h43, "R11 new byte value", int'(d[7:0]), 8'h43);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule